// File: doc/BRIEF.md
# Synchronous Output Clock Stop Controller

This block sits between the frequency synthesis section of a clock generator and its output drivers. It decides, for every generated clock, whether that clock is passed through or parked, and makes the change only at a point in the clock's own waveform where no shortened or lengthened pulse can appear. It handles a set of differential processor clock pairs, a group of stoppable bus clocks, a group of bus clocks that can be marked free-running, and auxiliary reference and fixed-frequency outputs.

Three active-low requests act on it. The processor stop request parks the pairs that software marked stoppable. The bus stop request parks the bus clocks and is combined with a stop bit held in a register. The power-down request parks everything. Each request is sampled on edges of the clock domain it controls before it takes effect. The whole block runs on one fast sampling clock; the generated clocks arrive as levels sampled by that clock, and every output leaves from a register.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While reset is held, every pair shows true high, complement low and drive enabled, and every single-ended output is low. After reset every enabled output starts following its source.
- R2: With the processor stop request low, each pair whose stoppable bit is 1 parks with true high and complement low once the request has been seen on two falling edges of the processor source clock. Pairs whose stoppable bit is 0 keep running.
- R3: After the processor stop request returns high, a parked pair shows its first falling transition of true within four processor source periods.
- R4: The effective bus stop is the AND of the bus stop pin and the register stop bit; a low on either parks every stoppable bus output low.
- R5: A free-running bus output is stopped by the bus stop only when its stoppable bit is 1; with the bit at 0 it keeps running.
- R6: The bus run status output is 0 whenever the bus stop pin or the register stop bit is low, and 1 otherwise.
- R7: After the effective bus stop returns high, parked bus outputs change again within four bus source periods.
- R8: When the power-down request has been seen low on two falling edges of the processor source clock (rising edges of its complement), every single-ended output is held low, including free-running and unstoppable ones, and every pair parks with true high and complement low regardless of its stoppable bit.
- R9: The pair drive enable is 1 except during power-down with the high-impedance select bit at 1, in which case it is 0 for every pair.
- R10: An enable bit at 0 forces its bus, free-running or auxiliary output low; at 1 the output follows its source.
- R11: No output ever shows a level lasting less than half of its source period; gating decisions take effect only while the source sits at the parked level (high for pair true, low for single-ended outputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_clk_in | input | 1 | Processor source clock level (true phase) |
| pci_clk_in | input | 1 | Bus source clock level |
| aux_clk_in | input | NUM_AUX | Auxiliary source clock levels |
| cpu_stop_n | input | 1 | Processor stop request, active low |
| pci_stop_n | input | 1 | Bus stop pin, active low |
| pwr_down_n | input | 1 | Power-down request, active low |
| pci_stop_reg | input | 1 | Register bus stop bit, 0 stops |
| cpu_stoppable | input | NUM_CPU | Per-pair stoppable select |
| pcif_stoppable | input | NUM_PCIF | Per free-running output stoppable select |
| pci_en | input | NUM_PCI | Per bus output enable |
| pcif_en | input | NUM_PCIF | Per free-running output enable |
| aux_en | input | NUM_AUX | Per auxiliary output enable |
| cpu_pd_hiz | input | 1 | Power-down park select: 0 true high/complement low, 1 high impedance |
| cpu_t | output | NUM_CPU | Gated pair true outputs |
| cpu_c | output | NUM_CPU | Gated pair complement outputs |
| cpu_oe | output | NUM_CPU | Pair drive enable, 0 means high impedance |
| pci_out | output | NUM_PCI | Gated stoppable bus outputs |
| pcif_out | output | NUM_PCIF | Gated free-running bus outputs |
| aux_out | output | NUM_AUX | Gated auxiliary outputs |
| pci_run_status | output | 1 | Read value of the combined bus stop, 0 when stopped |

## Verification
A gate flop that opened or closed in the wrong phase would show at the ports as a pulse shorter than half a source period, which the pulse-width monitor catches on the first such pulse. A synchronizer stage stuck or mis-sampled shows as an output that fails to park within the settle window or fails to resume within four source periods. A wrong combination of masks, enables and power-down shows as a parked level that differs from the expected one over a sixteen-cycle observation window after settling.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

    typedef struct packed {
        logic prev;
        logic s1;
        logic s2;
    } sync_st_t;

    typedef struct packed {
        logic run;
        logic out;
    } se_gate_st_t;

    typedef struct packed {
        logic run;
        logic hiz;
        logic t;
        logic c;
    } diff_gate_st_t;

endpackage

// File: rtl/stop_edge_sync.sv
module stop_edge_sync
    import clk_stop_pkg::*;
#(
    parameter bit SAMPLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic req_n_i,
    output logic sync_n_o
);

    sync_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_i;
        hit       = (src_i == SAMPLE_LEVEL) && (st_q.prev != SAMPLE_LEVEL);
        if (hit) begin
            st_d.s1 = req_n_i;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: SAMPLE_LEVEL, s1: 1'b1, s2: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_n_o = st_q.s2;

    logic s2_mon;
    assign s2_mon = st_q.s2;

    // Synchronized request moves only on a sampling edge of its domain (R2, R8)
    assert_sync_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s2_mon) |-> $past(hit));

endmodule

// File: rtl/clk_gate_se.sv
module clk_gate_se
    import clk_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic run_req_i,
    output logic out_o
);

    se_gate_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = src_i ? st_q.run : run_req_i;
        st_d.out = st_q.run ? src_i : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, out: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    logic run_mon;
    assign run_mon = st_q.run;

    // Gate decision changes only while the source sits low
    assert_gate_low_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_mon) |-> !$past(src_i));

    // A closed gate yields a low output on the following cycle (R4, R8, R10)
    assert_parked_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run_mon) |-> !out_o);

endmodule

// File: rtl/clk_gate_diff.sv
module clk_gate_diff
    import clk_stop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic run_req_i,
    input  logic hiz_req_i,
    output logic t_o,
    output logic c_o,
    output logic oe_o
);

    diff_gate_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = src_i ? run_req_i : st_q.run;
        st_d.hiz = src_i ? hiz_req_i : st_q.hiz;
        st_d.t   = st_q.run ? src_i  : 1'b1;
        st_d.c   = st_q.run ? ~src_i : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, hiz: 1'b0, t: 1'b1, c: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign t_o  = st_q.t;
    assign c_o  = st_q.c;
    assign oe_o = ~st_q.hiz;

    logic run_mon, hiz_mon;
    assign run_mon = st_q.run;
    assign hiz_mon = st_q.hiz;

    // Pair decision changes only while the true source sits high
    assert_pair_high_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_mon) |-> $past(src_i));

    // Parked pair shows true high, complement low
    assert_pair_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run_mon) |-> (t_o && !c_o));

    // True and complement are always opposite
    assert_pair_complement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        t_o != c_o);

    // Drive enable moves only in the high phase of the source
    assert_hiz_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hiz_mon) |-> $past(src_i));

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
    parameter int NUM_CPU  = 2,
    parameter int NUM_PCI  = 6,
    parameter int NUM_PCIF = 2,
    parameter int NUM_AUX  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_clk_in,
    input  logic                pci_clk_in,
    input  logic [NUM_AUX-1:0]  aux_clk_in,
    input  logic                cpu_stop_n,
    input  logic                pci_stop_n,
    input  logic                pwr_down_n,
    input  logic                pci_stop_reg,
    input  logic [NUM_CPU-1:0]  cpu_stoppable,
    input  logic [NUM_PCIF-1:0] pcif_stoppable,
    input  logic [NUM_PCI-1:0]  pci_en,
    input  logic [NUM_PCIF-1:0] pcif_en,
    input  logic [NUM_AUX-1:0]  aux_en,
    input  logic                cpu_pd_hiz,
    output logic [NUM_CPU-1:0]  cpu_t,
    output logic [NUM_CPU-1:0]  cpu_c,
    output logic [NUM_CPU-1:0]  cpu_oe,
    output logic [NUM_PCI-1:0]  pci_out,
    output logic [NUM_PCIF-1:0] pcif_out,
    output logic [NUM_AUX-1:0]  aux_out,
    output logic                pci_run_status
);

    logic cpu_run_sync;
    logic pd_run_sync;
    logic pci_run_sync;
    logic pci_stop_comb_n;

    assign pci_stop_comb_n = pci_stop_n & pci_stop_reg;
    assign pci_run_status  = pci_stop_comb_n;

    // Processor stop and power-down both sample on falling true edges
    stop_edge_sync #(.SAMPLE_LEVEL(1'b0)) u_cpu_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (cpu_clk_in),
        .req_n_i  (cpu_stop_n),
        .sync_n_o (cpu_run_sync)
    );

    stop_edge_sync #(.SAMPLE_LEVEL(1'b0)) u_pd_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (cpu_clk_in),
        .req_n_i  (pwr_down_n),
        .sync_n_o (pd_run_sync)
    );

    stop_edge_sync #(.SAMPLE_LEVEL(1'b1)) u_pci_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (pci_clk_in),
        .req_n_i  (pci_stop_comb_n),
        .sync_n_o (pci_run_sync)
    );

    logic [NUM_CPU-1:0]  cpu_req;
    logic [NUM_PCI-1:0]  pci_req;
    logic [NUM_PCIF-1:0] pcif_req;
    logic [NUM_AUX-1:0]  aux_req;
    logic                hiz_req;

    always_comb begin
        hiz_req = ~pd_run_sync & cpu_pd_hiz;
        for (int i = 0; i < NUM_CPU; i++) begin
            cpu_req[i] = pd_run_sync & ~(cpu_stoppable[i] & ~cpu_run_sync);
        end
        for (int j = 0; j < NUM_PCI; j++) begin
            pci_req[j] = pd_run_sync & pci_en[j] & pci_run_sync;
        end
        for (int k = 0; k < NUM_PCIF; k++) begin
            pcif_req[k] = pd_run_sync & pcif_en[k] & (~pcif_stoppable[k] | pci_run_sync);
        end
        for (int a = 0; a < NUM_AUX; a++) begin
            aux_req[a] = pd_run_sync & aux_en[a];
        end
    end

    for (genvar gi = 0; gi < NUM_CPU; gi++) begin : g_cpu
        clk_gate_diff u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (cpu_clk_in),
            .run_req_i (cpu_req[gi]),
            .hiz_req_i (hiz_req),
            .t_o       (cpu_t[gi]),
            .c_o       (cpu_c[gi]),
            .oe_o      (cpu_oe[gi])
        );
    end

    for (genvar gj = 0; gj < NUM_PCI; gj++) begin : g_pci
        clk_gate_se u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (pci_clk_in),
            .run_req_i (pci_req[gj]),
            .out_o     (pci_out[gj])
        );
    end

    for (genvar gk = 0; gk < NUM_PCIF; gk++) begin : g_pcif
        clk_gate_se u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (pci_clk_in),
            .run_req_i (pcif_req[gk]),
            .out_o     (pcif_out[gk])
        );
    end

    for (genvar ga = 0; ga < NUM_AUX; ga++) begin : g_aux
        clk_gate_se u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (aux_clk_in[ga]),
            .run_req_i (aux_req[ga]),
            .out_o     (aux_out[ga])
        );
    end

    // Once power-down is synchronized, every bus output is low a cycle after its gate shuts (R8)
    assert_pd_pci_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pd_run_sync) && $past(!pci_clk_in) && !pd_run_sync && !pci_clk_in) |=> (pci_out == '0));

endmodule

// File: tb/clk_stop_ctrl_bench.sv
module clk_stop_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_clk_in, pci_clk_in;
    logic [3:0] aux_clk_in;
    logic       cpu_stop_n, pci_stop_n, pwr_down_n, pci_stop_reg, cpu_pd_hiz;
    logic [1:0] cpu_stoppable, pcif_stoppable, pcif_en;
    logic [5:0] pci_en;
    logic [3:0] aux_en;
    logic [1:0] cpu_t, cpu_c, cpu_oe, pcif_out;
    logic [5:0] pci_out;
    logic [3:0] aux_out;
    logic       pci_run_status;

    int checks = 0;
    int errors = 0;
    int mcyc   = 0;
    int scyc   = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    clk_stop_ctrl u_clk_stop_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_clk_in(cpu_clk_in), .pci_clk_in(pci_clk_in),
        .aux_clk_in(aux_clk_in), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .pwr_down_n(pwr_down_n), .pci_stop_reg(pci_stop_reg), .cpu_stoppable(cpu_stoppable),
        .pcif_stoppable(pcif_stoppable), .pci_en(pci_en), .pcif_en(pcif_en), .aux_en(aux_en),
        .cpu_pd_hiz(cpu_pd_hiz), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe),
        .pci_out(pci_out), .pcif_out(pcif_out), .aux_out(aux_out),
        .pci_run_status(pci_run_status)
    );

    // ids: 0-1 cpu_t, 2-3 cpu_c, 4-5 cpu_oe, 6-11 pci, 12-13 pcif, 14-17 aux, 18 status
    function automatic logic get_sig(int id);
        if (id < 2)  return cpu_t[id];
        if (id < 4)  return cpu_c[id-2];
        if (id < 6)  return cpu_oe[id-4];
        if (id < 12) return pci_out[id-6];
        if (id < 14) return pcif_out[id-12];
        if (id < 18) return aux_out[id-14];
        return pci_run_status;
    endfunction

    function automatic int half_of(int id);
        if (id < 4)  return 2;
        if (id < 14) return 4;
        return 3;
    endfunction

    typedef struct {
        int    when;
        int    id;
        logic  exp;
        string req;
    } sb_item_t;

    sb_item_t sbq[$];

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic expect_hold(int id, logic v, string req, int len);
        for (int k = 1; k <= len; k++) sbq.push_back('{mcyc + k, id, v, req});
    endtask

    task automatic wait_toggle(int id, string req, int limit);
        logic v0;
        bit   seen;
        v0   = get_sig(id);
        seen = 1'b0;
        for (int k = 0; k < limit && !seen; k++) begin
            @(negedge clk);
            if (get_sig(id) !== v0) seen = 1'b1;
        end
        checks++;
        if (!seen) begin
            errors++;
            $display("FAIL %s id %0d: actual no change in %0d cycles expected a change", req, id, limit);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Source clocks: processor period 4, bus period 8, auxiliary period 6
    initial begin
        cpu_clk_in = 1'b0; pci_clk_in = 1'b0; aux_clk_in = '0;
        forever begin
            @(negedge clk);
            scyc++;
            cpu_clk_in = ((scyc / 2) % 2) == 1;
            pci_clk_in = ((scyc / 4) % 2) == 1;
            for (int a = 0; a < 4; a++) aux_clk_in[a] = (((scyc + a) / 3) % 2) == 1;
        end
    end

    // Scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            mcyc++;
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].when == mcyc) begin
                    checks++;
                    if (get_sig(sbq[i].id) !== sbq[i].exp) begin
                        errors++;
                        $display("FAIL %s id %0d cycle %0d: actual %b expected %b",
                                 sbq[i].req, sbq[i].id, mcyc, get_sig(sbq[i].id), sbq[i].exp);
                    end
                    sbq.delete(i);
                end
            end
        end
    end

    // Pulse-width monitor for R11
    initial begin
        logic last [18];
        int   cnt  [18];
        bit   armed[18];
        for (int i = 0; i < 18; i++) begin last[i] = 1'b0; cnt[i] = 0; armed[i] = 1'b0; end
        @(posedge rst_n);
        for (int i = 0; i < 18; i++) last[i] = get_sig(i);
        forever begin
            @(posedge clk);
            #1;
            for (int i = 0; i < 18; i++) begin
                if (i == 4 || i == 5) continue;
                cnt[i]++;
                if (get_sig(i) !== last[i]) begin
                    if (armed[i]) begin
                        checks++;
                        if (cnt[i] < half_of(i)) begin
                            errors++;
                            $display("FAIL R11 id %0d: actual pulse %0d cycles expected at least %0d",
                                     i, cnt[i], half_of(i));
                        end
                    end
                    armed[i] = 1'b1;
                    cnt[i]   = 0;
                    last[i]  = get_sig(i);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        rst_n = 1'b0;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwr_down_n = 1'b1; pci_stop_reg = 1'b1;
        cpu_pd_hiz = 1'b0; cpu_stoppable = 2'b11; pcif_stoppable = 2'b01;
        pci_en = '1; pcif_en = '1; aux_en = '1;
        idle(3);
        // R1 reset state
        chk("R1", cpu_t[0], 1'b1, "cpu_t in reset");
        chk("R1", cpu_c[1], 1'b0, "cpu_c in reset");
        chk("R1", cpu_oe[0], 1'b1, "cpu_oe in reset");
        chk("R1", |pci_out, 1'b0, "pci_out in reset");
        chk("R1", |aux_out, 1'b0, "aux_out in reset");
        chk("R6", pci_run_status, 1'b1, "status with no stop");
        rst_n = 1'b1;
        idle(40);
        wait_toggle(0, "R1", 8);
        wait_toggle(6, "R1", 16);
        wait_toggle(13, "R1", 16);
        wait_toggle(14, "R1", 12);

        // R2/R3 processor stop on pair 0 only
        cpu_stoppable = 2'b01;
        cpu_stop_n = 1'b0;
        idle(40);
        expect_hold(0, 1'b1, "R2", 16);
        expect_hold(2, 1'b0, "R2", 16);
        wait_toggle(1, "R2", 8);
        idle(17);
        cpu_stop_n = 1'b1;
        wait_toggle(0, "R3", 16);
        idle(20);

        // R4/R5/R6/R7 bus stop through the pin
        pci_stop_n = 1'b0;
        #1;
        chk("R6", pci_run_status, 1'b0, "status with pin low");
        idle(40);
        for (int j = 6; j < 12; j++) expect_hold(j, 1'b0, "R4", 16);
        expect_hold(12, 1'b0, "R5", 16);
        expect_hold(18, 1'b0, "R6", 16);
        wait_toggle(13, "R5", 16);
        idle(17);
        pci_stop_n = 1'b1;
        #1;
        chk("R6", pci_run_status, 1'b1, "status after pin release");
        wait_toggle(6, "R7", 32);
        wait_toggle(12, "R7", 32);
        idle(20);

        // R4/R6 bus stop through the register bit
        pci_stop_reg = 1'b0;
        #1;
        chk("R6", pci_run_status, 1'b0, "status with register bit low");
        idle(40);
        expect_hold(8, 1'b0, "R4", 16);
        expect_hold(11, 1'b0, "R4", 16);
        idle(17);
        pci_stop_reg = 1'b1;
        wait_toggle(8, "R7", 32);
        idle(20);

        // R10 enables
        pci_en = 6'b111011; pcif_en = 2'b01; aux_en = 4'b1101;
        idle(40);
        expect_hold(8, 1'b0, "R10", 16);
        expect_hold(13, 1'b0, "R10", 16);
        expect_hold(15, 1'b0, "R10", 16);
        wait_toggle(7, "R10", 16);
        idle(17);
        pci_en = '1; pcif_en = '1; aux_en = '1;
        idle(40);
        wait_toggle(8, "R10", 16);
        wait_toggle(15, "R10", 12);

        // R8/R9 power-down, unstoppable pairs still park
        cpu_stoppable = 2'b00;
        pwr_down_n = 1'b0;
        idle(40);
        expect_hold(0, 1'b1, "R8", 16);
        expect_hold(1, 1'b1, "R8", 16);
        expect_hold(2, 1'b0, "R8", 16);
        expect_hold(3, 1'b0, "R8", 16);
        expect_hold(4, 1'b1, "R9", 16);
        expect_hold(6, 1'b0, "R8", 16);
        expect_hold(13, 1'b0, "R8", 16);
        for (int a = 14; a < 18; a++) expect_hold(a, 1'b0, "R8", 16);
        idle(17);
        cpu_pd_hiz = 1'b1;
        idle(20);
        expect_hold(4, 1'b0, "R9", 16);
        expect_hold(5, 1'b0, "R9", 16);
        idle(17);
        pwr_down_n = 1'b1;
        cpu_pd_hiz = 1'b0;
        idle(40);
        expect_hold(4, 1'b1, "R9", 16);
        expect_hold(5, 1'b1, "R9", 16);
        wait_toggle(1, "R8", 8);
        idle(20);

        while (sbq.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule